// File: doc/BRIEF.md
# Clock Monitor Error Detector

This block judges whether the main system clock is running fast enough. It compares the main clock against a slow, free-running reference tick, for example one coming from a low-frequency RC oscillator. It does this by counting main-clock cycles between consecutive reference ticks. A window shorter than the parameter `MIN_EDGES` means the clock is too slow. The block then drives an active-low error pin, and it also reports the result of the latest window on a status flag.

The monitor comes out of reset already armed, because its enable bit resets to one. The error pin is therefore low straight after reset, and it stays low until a full reference window proves the clock good. After a good window the error is not released at once. A 5-bit settle counter is loaded with 16 and must wrap to zero before the pin goes high, so release comes 16 to 32 main-clock cycles after the reference tick. A short window seen during the settle phase cancels it.

Software can clear the enable bit through a one-bit write port. Doing so silences the pin and clears all measurement state. Setting the bit again re-arms the monitor exactly as a reset release does.

Top module: `clkmon_guard`

## Requirements
- R1: While `rst_n` is low, `err_n_o` is high and `slow_o` is low.
- R2: The enable bit resets to 1. On the first clock edge after `rst_n` goes high, the monitor arms: `err_n_o` goes low and `slow_o` goes high.
- R3: `ref_tick_i` passes through a two-flop synchroniser, and its rising edges are timed in main-clock cycles. A window of P cycles between rising edges is good when P >= `MIN_EDGES` (default 32). The window result appears on `slow_o` (1 = too slow) three cycles after the rising edge of the tick that closes the window.
- R4: The first tick after reset or after re-enabling only opens a window. It produces no judgement, so the error cannot be released by it.
- R5: While in error, a good window loads the settle counter with 16. `err_n_o` goes high on the 20th clock edge after the closing tick is raised (synchroniser, judge and 16-cycle settle). This is within 16 to 32 cycles of the tick.
- R6: A short window that is judged during the settle phase returns the monitor to error and clears the settle counter. `err_n_o` stays low until a later good window completes a full settle.
- R7: When the error is released, a short window drives `err_n_o` low on the 4th clock edge after the closing tick is raised.
- R8: A window of `MIN_EDGES`-1 cycles is judged too slow, and a window of exactly `MIN_EDGES` cycles is judged good.
- R9: Writing 0 to the enable bit (`en_we_i`=1, `en_wd_i`=0) drives `err_n_o` high and `slow_o` low by the second edge after the write edge. Reference ticks have no effect while the bit is 0.
- R10: Writing 1 to the enable bit re-arms the monitor: `err_n_o` goes low on the second edge after the write edge. Release then follows R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main system clock being monitored |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick_i | input | 1 | Asynchronous slow reference tick, timed on its rising edge |
| en_we_i | input | 1 | Write strobe for the enable bit |
| en_wd_i | input | 1 | Value written to the enable bit |
| err_n_o | output | 1 | Active-low clock error pin |
| slow_o | output | 1 | Status flag: latest judged window was too slow |

## Verification
The bench drives reference windows exactly one cycle either side of the threshold. A design that compares with an off-by-one bound would release on a 31-cycle window, or hold the error on a 32-cycle one. Release timing is checked on the cycle before the release edge and on the release edge itself, so a settle counter loaded with the wrong start value, or released one state early, shifts the edge and is reported. Further scenarios use short windows to land a relapse inside the settle phase and to discard the first window after reset and after re-enable. A design that lets the old settle run finish, or judges a partial window, releases too early. Ticks sent while the monitor is disabled, followed by re-enabling it, expose a disabled monitor that still pulls the pin or keeps stale window state.

// File: rtl/clkmon_pkg.sv
// Shared types for the clock monitor.
// Assumes: all users are clocked by the monitored main clock.
package clkmon_pkg;

    // Arming / release state of the monitor.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,  // disabled or in reset: pin released
        ST_FAULT  = 2'd1,  // clock not proven good: pin low
        ST_SETTLE = 2'd2,  // good window seen, settle counter running: pin low
        ST_OK     = 2'd3   // clock good: pin high
    } mon_state_e;

endpackage

// File: rtl/clkmon_tick_sync.sv
// Brings the asynchronous reference tick into the main-clock domain and
// turns each rising edge into a one-cycle pulse.
// Assumes: the tick stays high and low for at least SYNC_STAGES cycles each.
module clkmon_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async_i,
    output logic rise_pulse_o
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift chain: SYNC_STAGES synchroniser flops plus one edge-detect flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], tick_async_i};
        end
    end

    // Rising edge seen at the output of the synchroniser.
    assign rise_pulse_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    // R3: each tick edge yields a single-cycle pulse.
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse_o |=> !rise_pulse_o);

endmodule

// File: rtl/clkmon_period_judge.sv
// Counts main-clock cycles between synchronised reference pulses and
// judges each completed window against MIN_EDGES.
// Assumes: MIN_EDGES >= 2; clear_i holds the judge idle.
module clkmon_period_judge #(
    parameter int MIN_EDGES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic pulse_i,
    output logic judge_stb_o,
    output logic judge_good_o
);

    localparam int CNT_W = (MIN_EDGES > 2) ? $clog2(MIN_EDGES) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_EDGES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;
    logic             stb_q;
    logic             good_q;

    // Window counter, first-pulse flag and registered judgement.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
            stb_q  <= 1'b0;
            good_q <= 1'b0;
        end else begin
            stb_q <= pulse_i & seen_q;
            if (pulse_i) begin
                cnt_q  <= '0;
                seen_q <= 1'b1;
                if (seen_q) begin
                    good_q <= (cnt_q >= LIMIT);
                end
            end else if (cnt_q != LIMIT) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign judge_stb_o  = stb_q;
    assign judge_good_o = good_q;

    // R3: a judgement only follows a synchronised tick pulse.
    p_stb_after_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        judge_stb_o |-> $past(pulse_i));

    // R4: no judgement until a first window has been opened.
    p_first_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        judge_stb_o |-> $past(seen_q));

    // R9: clearing leaves no judgement behind.
    p_clear_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!judge_stb_o && !judge_good_o));

endmodule

// File: rtl/clkmon_settle_fsm.sv
// Arming state machine with the release settle counter.
// Assumes: judge_stb_i is a one-cycle strobe qualifying judge_good_i.
module clkmon_settle_fsm
    import clkmon_pkg::*;
#(
    parameter int SETTLE_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic judge_stb_i,
    input  logic judge_good_i,
    output logic err_active_o,
    output logic mon_active_o
);

    localparam logic [SETTLE_W-1:0] SETTLE_START = SETTLE_W'(1) << (SETTLE_W - 1);
    localparam logic [SETTLE_W-1:0] SETTLE_LAST  = '1;

    mon_state_e        state_q;
    logic [SETTLE_W-1:0] settle_q;
    logic              bad_window;

    // A completed window that was too short.
    assign bad_window = judge_stb_i & ~judge_good_i;

    // State and settle counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            state_q  <= ST_IDLE;
            settle_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    state_q  <= ST_FAULT;
                    settle_q <= '0;
                end
                ST_FAULT: begin
                    if (judge_stb_i && judge_good_i) begin
                        state_q  <= ST_SETTLE;
                        settle_q <= SETTLE_START;
                    end
                end
                ST_SETTLE: begin
                    if (bad_window) begin
                        state_q  <= ST_FAULT;
                        settle_q <= '0;
                    end else begin
                        settle_q <= settle_q + 1'b1;
                        if (settle_q == SETTLE_LAST) begin
                            state_q <= ST_OK;
                        end
                    end
                end
                default: begin
                    if (bad_window) begin
                        state_q <= ST_FAULT;
                    end
                end
            endcase
        end
    end

    assign err_active_o = (state_q == ST_FAULT) || (state_q == ST_SETTLE);
    assign mon_active_o = (state_q != ST_IDLE);

    // R2/R10: an enabled idle monitor arms on the next edge.
    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && enable_i) |=> (state_q == ST_FAULT));

    // R5: the released state is only entered from the settle phase.
    p_release_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OK && $past(state_q) != ST_OK) |-> ($past(state_q) == ST_SETTLE));

    // R5: the settle counter stays in its upper half while running.
    p_settle_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> settle_q[SETTLE_W-1]);

    // R6/R7: a short window while enabled always lands in the fault state.
    p_relapse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && bad_window && state_q != ST_IDLE) |=> (state_q == ST_FAULT || !enable_i));

endmodule

// File: rtl/clkmon_guard.sv
// Clock monitor top: enable bit, reference synchroniser, window judge and
// arming state machine; drives the active-low error pin and status flag.
// Assumes: clk is the clock under watch; ref_tick_i is asynchronous and slow.
module clkmon_guard #(
    parameter int MIN_EDGES   = 32,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_W    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick_i,
    input  logic en_we_i,
    input  logic en_wd_i,
    output logic err_n_o,
    output logic slow_o
);

    logic en_q;
    logic rise_pulse;
    logic judge_stb;
    logic judge_good;
    logic err_active;
    logic mon_active;

    // Enable bit: set by reset, written through the one-bit port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b1;
        end else if (en_we_i) begin
            en_q <= en_wd_i;
        end
    end

    clkmon_tick_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) sync_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_async_i (ref_tick_i),
        .rise_pulse_o (rise_pulse)
    );

    clkmon_period_judge #(
        .MIN_EDGES (MIN_EDGES)
    ) judge_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (~en_q),
        .pulse_i      (rise_pulse),
        .judge_stb_o  (judge_stb),
        .judge_good_o (judge_good)
    );

    clkmon_settle_fsm #(
        .SETTLE_W (SETTLE_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (en_q),
        .judge_stb_i  (judge_stb),
        .judge_good_i (judge_good),
        .err_active_o (err_active),
        .mon_active_o (mon_active)
    );

    assign err_n_o = ~err_active;
    assign slow_o  = mon_active & ~judge_good;

    // R1: reset keeps the pin released and the flag clear.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (err_n_o && !slow_o));

    // R9: a cleared enable bit releases the pin.
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (err_n_o && !slow_o));

endmodule

// File: tb/clkmon_guard_tb_top.sv
`timescale 1ns/1ps
module clkmon_guard_tb_top;

    logic clk;
    logic rst_n;
    logic ref_tick;
    logic en_we;
    logic en_wd;
    logic err_n;
    logic slow;

    int checks   = 0;
    int failures = 0;

    clkmon_guard #(
        .MIN_EDGES   (32),
        .SYNC_STAGES (2),
        .SETTLE_W    (5)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick),
        .en_we_i    (en_we),
        .en_wd_i    (en_wd),
        .err_n_o    (err_n),
        .slow_o     (slow)
    );

    // 200 MHz clock.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Raise the reference tick, lower it after 3 cycles, return after n cycles.
    task automatic tick_then(input int n);
        ref_tick = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i == 3) ref_tick = 1'b0;
        end
    endtask

    task automatic write_enable(input logic v);
        en_we = 1'b1;
        en_wd = v;
        step(1);
        en_we = 1'b0;
    endtask

    task automatic t_reset();
        step(3);
        chk("R1 err_n in reset", err_n, 1'b1);
        chk("R1 slow in reset", slow, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R2 armed err_n", err_n, 1'b0);
        chk("R2 armed slow", slow, 1'b1);
    endtask

    task automatic t_release();
        tick_then(40);
        chk("R4 first window ignored", err_n, 1'b0);
        tick_then(19);
        chk("R5 still low at edge 19", err_n, 1'b0);
        chk("R3 good window flag", slow, 1'b0);
        step(1);
        chk("R5 release at edge 20", err_n, 1'b1);
        step(20);
    endtask

    task automatic t_drop_and_boundary();
        tick_then(20);
        chk("R7 good window keeps release", err_n, 1'b1);
        tick_then(3);
        chk("R3 short window flag", slow, 1'b1);
        chk("R7 not yet low at edge 3", err_n, 1'b1);
        step(1);
        chk("R7 low at edge 4", err_n, 1'b0);
        step(27);
        tick_then(20);
        chk("R8 window MIN-1 slow", slow, 1'b1);
        chk("R8 window MIN-1 keeps error", err_n, 1'b0);
        step(12);
        tick_then(19);
        chk("R8 window MIN settle", err_n, 1'b0);
        chk("R8 window MIN good", slow, 1'b0);
        step(1);
        chk("R8 window MIN releases", err_n, 1'b1);
        step(20);
    endtask

    task automatic t_abort();
        tick_then(15);
        tick_then(3);
        step(1);
        chk("R7 relapse low", err_n, 1'b0);
        step(36);
        tick_then(10);
        tick_then(10);
        chk("R6 settle aborted", err_n, 1'b0);
        step(30);
        tick_then(19);
        chk("R6 fresh settle not done", err_n, 1'b0);
        step(1);
        chk("R6 fresh settle releases", err_n, 1'b1);
        step(20);
    endtask

    task automatic t_disable();
        tick_then(8);
        tick_then(6);
        chk("R7 fault before disable", err_n, 1'b0);
        write_enable(1'b0);
        step(1);
        chk("R9 disable err_n", err_n, 1'b1);
        chk("R9 disable slow", slow, 1'b0);
        for (int k = 0; k < 3; k++) begin
            tick_then(10);
            chk("R9 ticks ignored err_n", err_n, 1'b1);
            chk("R9 ticks ignored slow", slow, 1'b0);
        end
        step(10);
    endtask

    task automatic t_reenable();
        write_enable(1'b1);
        step(1);
        chk("R10 re-armed err_n", err_n, 1'b0);
        chk("R10 re-armed slow", slow, 1'b1);
        tick_then(40);
        chk("R4 first window after enable ignored", err_n, 1'b0);
        tick_then(19);
        chk("R10 settle after enable", err_n, 1'b0);
        step(1);
        chk("R10 release after enable", err_n, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        ref_tick = 1'b0;
        en_we    = 1'b0;
        en_wd    = 1'b0;
        t_reset();
        t_release();
        t_drop_and_boundary();
        t_abort();
        t_disable();
        t_reenable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule